// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. The pins are grouped in banks of 32, and there are up to seven banks. Each bank provides a readable pin level, a direction word, and write-one set and clear ports that drive its output latch. It also has rising-edge and falling-edge enable words, a sticky edge-status word and an edge mask that gates events towards the processor. Software reaches the registers over a simple bus that completes in one cycle. A write is taken on the clock edge where the strobe is high. Read data is valid in the same cycle as the address.

Pin inputs are synchronised with two flops before they are used. The synchronised value is then compared with its value one clock earlier to find edges. An edge on a pin whose matching enable is set latches that pin's status bit, and the bit stays set until software writes a one to it. Pins 0 and 1 each have their own interrupt output. Masked-in pending events on every other pin are ORed onto one shared interrupt output.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0, and pin_out, pin_oe and all three interrupt outputs are 0.
- R2: Bank n lives at byte offset (n div 3)*0x100 + (n mod 3)*4. Added to that offset are the register offsets: 0x00 level, 0x0C direction, 0x18 set, 0x24 clear, 0x30 rising enable, 0x3C falling enable, 0x48 status and 0x9C mask. Any address that is misaligned, that decodes to no register, or that names a bank at or above NUM_BANKS reads 0 and has no effect when written.
- R3: A write to the set register forces to 1 every pin_out bit whose data bit is 1. A write to the clear register forces those bits to 0. Data bits that are 0 leave pin_out unchanged.
- R4: The direction register drives pin_oe, where 1 means output and 0 means input. It reads back as written.
- R5: The level register returns pin_in after two flops. A change that is set up before clock edge k can be read from the level register once edge k+1 has passed.
- R6: A status bit latches on a rising edge of its synchronised pin when its rising enable is 1, and on a falling edge when its falling enable is 1. Both enables may be active together. A transition whose enable is 0 leaves the bit at 0. A pin change set up before edge k shows in the status register after edge k+2.
- R7: Writing to the status register clears every bit whose data bit is 1. Data bits that are 0 leave their status bits alone. When a new event and a clearing write hit the same bit in the same cycle, the bit stays 1.
- R8: irq_pin0 and irq_pin1 are the status bit ANDed with the mask bit for pins 0 and 1 of bank 0. irq_shared is the OR of status AND mask over all other pins. A pending bit with mask 0 raises no interrupt.
- R9: Reads of the set and clear addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| pin_in | input | NUM_BANKS*32 | Pin input levels, asynchronous |
| pin_out | output | NUM_BANKS*32 | Output latch values |
| pin_oe | output | NUM_BANKS*32 | Output enable per pin (direction) |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_shared | output | 1 | Combined interrupt for pins 2 and up |

## Verification
The address decode is tried with bank offsets in the first, second and third group of three. This tells a correct group and slot split apart from a flat stride. The decode is also tried with a bank index past the last bank and with misaligned addresses, which must hit nothing. Set and clear are tried with overlapping patterns, so that a write acting as a plain store is told apart from a read-modify-write. The edge logic is driven with a rise on an enable-only-rising pin, a fall on that pin, and both directions on a dual-enabled pin, which tells the polarity gating apart. A clearing write is landed in the exact cycle of a new event to show which one has priority. The interrupts are exercised with pending bits that are masked and unmasked on pin 0, on pin 5 and on a pin in bank 3, which shows the routing to the dedicated and shared lines.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int WORD_W     = 32;
    localparam int MAX_BANKS  = 7;
    localparam int ADDR_W     = 12;
    localparam int BANK_IDX_W = $clog2(MAX_BANKS);

    typedef enum logic [3:0] {
        K_LEVEL,
        K_DIR,
        K_SET,
        K_CLR,
        K_RISE,
        K_FALL,
        K_STAT,
        K_MASK,
        K_NONE
    } reg_kind_e;

    typedef struct packed {
        logic                  hit;
        logic [BANK_IDX_W-1:0] bank;
        reg_kind_e             kind;
    } dec_t;

    // Word index inside a 256-byte group = kind*3 + slot; mask sits at word 39.
    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int nbanks);
        dec_t d;
        int   word;
        int   slot;
        int   kidx;
        int   bank;
        word = int'(a[7:2]);
        slot = word % 3;
        kidx = word / 3;
        bank = int'(a[ADDR_W-1:8]) * 3 + slot;
        case (kidx)
            0:       d.kind = K_LEVEL;
            1:       d.kind = K_DIR;
            2:       d.kind = K_SET;
            3:       d.kind = K_CLR;
            4:       d.kind = K_RISE;
            5:       d.kind = K_FALL;
            6:       d.kind = K_STAT;
            13:      d.kind = K_MASK;
            default: d.kind = K_NONE;
        endcase
        d.hit  = (a[1:0] == 2'b00) && (d.kind != K_NONE) && (bank < nbanks);
        d.bank = d.hit ? BANK_IDX_W'(bank) : '0;
        return d;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1, s2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= '0;
            s2   <= '0;
            prev <= '0;
        end else begin
            s1   <= din;
            s2   <= s1;
            prev <= s2;
        end
    end

    assign level = s2;
    assign rise  = s2 & ~prev;
    assign fall  = ~s2 & prev;

    // R5
    level_lag_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (level == $past(din, 2)));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] sync_level,
    input  logic [W-1:0] rise_raw,
    input  logic [W-1:0] fall_raw,
    output logic [W-1:0] rdata,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] irq_vec
);
    logic [W-1:0] rise_en, fall_en, stat, mask;
    logic [W-1:0] ev, w1c;

    assign ev  = (rise_raw & rise_en) | (fall_raw & fall_en);
    assign w1c = (wr && kind == K_STAT) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            dir_q   <= '0;
            rise_en <= '0;
            fall_en <= '0;
            stat    <= '0;
            mask    <= '0;
        end else begin
            if (wr) begin
                case (kind)
                    K_DIR:   dir_q   <= wdata;
                    K_SET:   out_q   <= out_q | wdata;
                    K_CLR:   out_q   <= out_q & ~wdata;
                    K_RISE:  rise_en <= wdata;
                    K_FALL:  fall_en <= wdata;
                    K_MASK:  mask    <= wdata;
                    default: ;
                endcase
            end
            stat <= (stat & ~w1c) | ev;
        end
    end

    always_comb begin
        case (kind)
            K_LEVEL: rdata = sync_level;
            K_DIR:   rdata = dir_q;
            K_RISE:  rdata = rise_en;
            K_FALL:  rdata = fall_en;
            K_STAT:  rdata = stat;
            K_MASK:  rdata = mask;
            default: rdata = '0;
        endcase
    end

    assign irq_vec = stat & mask;

    // R3
    set_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && kind == K_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

    // R3
    clr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && kind == K_CLR) |=> ((out_q & $past(wdata)) == '0));

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && kind == K_STAT) |=> ((stat & $past(wdata) & ~$past(ev)) == '0));

    // R6
    stat_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ((stat & ~$past(stat) & ~($past(rise_en) | $past(fall_en))) == '0));

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = MAX_BANKS,
    localparam int NUM_PINS = NUM_BANKS * WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_pin0,
    output logic                irq_pin1,
    output logic                irq_shared
);
    dec_t               dec;
    logic [WORD_W-1:0]  bank_rd [NUM_BANKS];
    logic [NUM_PINS-1:0] irq_all;

    assign dec = decode_addr(bus_addr, NUM_BANKS);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [WORD_W-1:0] lvl, rs, fl;
        logic              hit_b;

        assign hit_b = dec.hit && (dec.bank == BANK_IDX_W'(b));

        gpio_sync #(.W(WORD_W)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .din   (pin_in[b*WORD_W +: WORD_W]),
            .level (lvl),
            .rise  (rs),
            .fall  (fl)
        );

        gpio_bank #(.W(WORD_W)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .wr         (bus_wr && hit_b),
            .kind       (dec.kind),
            .wdata      (bus_wdata),
            .sync_level (lvl),
            .rise_raw   (rs),
            .fall_raw   (fl),
            .rdata      (bank_rd[b]),
            .out_q      (pin_out[b*WORD_W +: WORD_W]),
            .dir_q      (pin_oe[b*WORD_W +: WORD_W]),
            .irq_vec    (irq_all[b*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (dec.hit && dec.bank == BANK_IDX_W'(b)) bus_rdata = bank_rd[b];
        end
    end

    assign irq_pin0   = irq_all[0];
    assign irq_pin1   = irq_all[1];
    assign irq_shared = |irq_all[NUM_PINS-1:2];

    // R4
    oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(pin_oe));

    // R2
    miss_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !dec.hit) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 7;
    localparam int NP = NB * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   addr = '0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq0, irq1, irqs;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_ctrl #(.NUM_BANKS(NB)) uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_pin0(irq0), .irq_pin1(irq1), .irq_shared(irqs)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pin_out low word", pin_out[31:0], 32'h0);
        check("R1 pin_oe top word", pin_oe[NP-1 -: 32], 32'h0);
        check("R1 irq lines", {29'h0, irq0, irq1, irqs}, 32'h0);
        bus_read(12'h048, v); check("R1 status bank0", v, 32'h0);
        bus_read(12'h19C, v); check("R1 mask bank3", v, 32'h0);
    endtask

    task automatic t_addr_map();
        logic [31:0] v;
        bus_write(12'h110, 32'hA5A5_0000);
        check("R2 bank4 dir to pins", pin_oe[159:128], 32'hA5A5_0000);
        check("R2 bank3 dir untouched", pin_oe[127:96], 32'h0);
        bus_write(12'h20C, 32'hDEAD_0001);
        check("R2 bank6 dir to pins", pin_oe[223:192], 32'hDEAD_0001);
        bus_write(12'h210, 32'hFFFF_FFFF);
        check("R2 absent bank7 no write bank6", pin_oe[223:192], 32'hDEAD_0001);
        check("R2 absent bank7 no write bank0", pin_oe[31:0], 32'h0);
        bus_read(12'h210, v); check("R2 absent bank reads 0", v, 32'h0);
        bus_read(12'h112, v); check("R2 misaligned reads 0", v, 32'h0);
        bus_read(12'h110, v); check("R2 bank4 dir readback", v, 32'hA5A5_0000);
    endtask

    task automatic t_set_clr();
        logic [31:0] v;
        bus_write(12'h018, 32'h0000_00F0);
        check("R3 set first", pin_out[31:0], 32'h0000_00F0);
        bus_write(12'h018, 32'h0000_000F);
        check("R3 set keeps earlier bits", pin_out[31:0], 32'h0000_00FF);
        bus_write(12'h024, 32'h0000_003C);
        check("R3 clear selected bits", pin_out[31:0], 32'h0000_00C3);
        bus_write(12'h120, 32'h8000_0001);
        check("R3 bank5 set", pin_out[191:160], 32'h8000_0001);
        check("R3 bank0 unchanged by bank5", pin_out[31:0], 32'h0000_00C3);
        bus_read(12'h018, v); check("R9 set reads 0", v, 32'h0);
        bus_read(12'h024, v); check("R9 clear reads 0", v, 32'h0);
    endtask

    task automatic t_dir();
        logic [31:0] v;
        bus_write(12'h00C, 32'h0000_FFFF);
        check("R4 dir drives oe", pin_oe[31:0], 32'h0000_FFFF);
        bus_read(12'h00C, v); check("R4 dir readback", v, 32'h0000_FFFF);
    endtask

    task automatic t_level();
        logic [31:0] v;
        pin_in[63:32] = 32'h1234_5678;
        settle(1);
        bus_read(12'h004, v); check("R5 level after one edge", v, 32'h0);
        settle(1);
        bus_read(12'h004, v); check("R5 level after two edges", v, 32'h1234_5678);
    endtask

    task automatic t_edges();
        logic [31:0] v;
        bus_write(12'h030, 32'h0000_0060);
        bus_write(12'h03C, 32'h0000_0040);
        pin_in[5] = 1'b1;
        settle(3);
        bus_read(12'h048, v); check("R6 rising pin5", v, 32'h0000_0020);
        bus_write(12'h048, 32'hFFFF_FFFF);
        pin_in[5] = 1'b0;
        settle(3);
        bus_read(12'h048, v); check("R6 fall disabled pin5", v, 32'h0);
        pin_in[6] = 1'b1;
        settle(3);
        bus_read(12'h048, v); check("R6 dual rise pin6", v, 32'h0000_0040);
        bus_write(12'h048, 32'h0000_0040);
        pin_in[6] = 1'b0;
        settle(3);
        bus_read(12'h048, v); check("R6 dual fall pin6", v, 32'h0000_0040);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        bus_write(12'h048, 32'h0000_0000);
        bus_read(12'h048, v); check("R7 zero write keeps", v, 32'h0000_0040);
        bus_write(12'h048, 32'h0000_0040);
        bus_read(12'h048, v); check("R7 one write clears", v, 32'h0);
        pin_in[5] = 1'b1;
        pin_in[6] = 1'b1;
        settle(3);
        bus_read(12'h048, v); check("R7 two pending", v, 32'h0000_0060);
        pin_in[6] = 1'b0;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        addr = 12'h048; wdata = 32'h0000_0060; wr = 1'b1;
        @(posedge clk); @(negedge clk);
        wr = 1'b0;
        bus_read(12'h048, v); check("R7 event beats clear", v, 32'h0000_0040);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        pin_in[5] = 1'b0;
        settle(3);
        bus_write(12'h048, 32'hFFFF_FFFF);
        bus_write(12'h030, 32'h0000_0023);
        bus_write(12'h09C, 32'h0000_0023);
        check("R8 idle irqs", {29'h0, irq0, irq1, irqs}, 32'h0);
        pin_in[0] = 1'b1;
        settle(3);
        check("R8 pin0 dedicated only", {29'h0, irq0, irq1, irqs}, 32'h4);
        pin_in[5] = 1'b1;
        settle(3);
        check("R8 pin5 shared", {29'h0, irq0, irq1, irqs}, 32'h5);
        bus_write(12'h048, 32'h0000_0001);
        check("R8 pin0 cleared", {29'h0, irq0, irq1, irqs}, 32'h1);
        bus_write(12'h048, 32'hFFFF_FFFF);
        check("R8 all cleared", {29'h0, irq0, irq1, irqs}, 32'h0);
        bus_write(12'h130, 32'h0000_0008);
        pin_in[99] = 1'b1;
        settle(3);
        bus_read(12'h148, v); check("R8 bank3 pending", v, 32'h0000_0008);
        check("R8 masked-out no irq", {31'h0, irqs}, 32'h0);
        bus_write(12'h19C, 32'h0000_0008);
        check("R8 unmask raises shared", {31'h0, irqs}, 32'h1);
    endtask

    initial begin
        settle(4);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_addr_map();
        t_set_clr();
        t_dir();
        t_level();
        t_edges();
        t_w1c();
        t_irq();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule